// File: doc/BRIEF.md
# Mono-Mode Audio Frame Duplicator

This block takes decoded audio frames from a digital audio receiver and turns them into parallel left/right word pairs for a serial audio output formatter. Each input frame carries two sub-frame samples, A and B, and is marked by a one-cycle frame strobe. A mode input selects stereo or mono operation.

In stereo operation, every frame produces one output word cycle. Sample A goes to the left slot and sample B goes to the right slot. In mono operation, A and B are two consecutive samples of one channel, so the output word rate is twice the frame rate. Sample A fills both slots of the first word cycle. Sample B is held internally and fills both slots of a second word cycle, half a frame period later.

The half period comes from the measured spacing of the incoming frame strobes. A rate indicator output shows when the doubled output rate is in force. If a new frame arrives before the held B word has been emitted, an overrun pulse is raised and the newer frame is used.

Top module: `aes_mono_dup`

## Requirements
- R1: While `rst_n` is low, and after its release with no frame yet received, `word_stb`, `left_word`, `right_word`, `rate_x2` and `overrun` are all 0.
- R2: In stereo operation (`mono_sel`=0 at the strobe), the clock edge that samples `frm_stb` high makes `word_stb` high for one cycle. At that edge `left_word` takes `sub_a` and `right_word` takes `sub_b`, with no reordering.
- R3: In mono operation (`mono_sel`=1 at the strobe), the clock edge that samples `frm_stb` high makes `word_stb` high for one cycle, with both `left_word` and `right_word` equal to `sub_a`.
- R4: In mono operation, a second word with both slots equal to that frame's `sub_b` appears exactly HALF edges after the A word. HALF is floor(P/2), where P is the number of cycles between the two most recent frame strobes. If fewer than two strobes have been seen since reset, HALF is 1.
- R5: The B sample emitted in mono operation is the `sub_b` value present at the frame strobe. Later changes of `sub_b` do not alter it.
- R6: The mode is sampled only at a frame strobe. `rate_x2` equals the `mono_sel` value captured at the most recent strobe. A change of `mono_sel` between strobes changes neither `rate_x2` nor the words still due from the current frame.
- R7: A frame strobe that arrives while a mono B word is still pending raises `overrun` for exactly one cycle, at the strobe edge. The pending B word is discarded, and the new frame's words are produced as in R2 to R4.
- R8: Each stereo frame produces exactly one `word_stb` pulse. Each completed mono frame produces exactly two. No other `word_stb` pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_stb | input | 1 | One-cycle strobe marking a valid input frame |
| sub_a | input | DATA_W (24) | Sub-frame A sample, valid with `frm_stb` |
| sub_b | input | DATA_W (24) | Sub-frame B sample, valid with `frm_stb` |
| mono_sel | input | 1 | 1 = mono operation, 0 = stereo operation; sampled at `frm_stb` |
| word_stb | output | 1 | One-cycle pulse per output word cycle |
| left_word | output | DATA_W (24) | Left slot word, valid with `word_stb` |
| right_word | output | DATA_W (24) | Right slot word, valid with `word_stb` |
| rate_x2 | output | 1 | High while the doubled output word rate (mono) is in force |
| overrun | output | 1 | One-cycle pulse when a frame arrives before the pending B word is emitted |

## Verification
Each kind of wrong internal state shows up at the ports, as follows:
- A stale or overwritten B hold register shows up in the second mono word, exactly HALF edges after the strobe, so the bench drives `sub_b` with unrelated values between strobes.
- A miscounted period or frame-spacing counter moves that second `word_stb` pulse by one or more cycles. The bench therefore checks every cycle between strobes for absent pulses, as well as the exact cycle where the pulse must appear.
- A mode register that follows `mono_sel` directly, instead of at a strobe, changes `rate_x2` and the duplication within a cycle of a mid-frame mode flip.
- A lost pending flag shows up as a missing `overrun` pulse, or a spurious B word, on the very next strobe edge.

// File: rtl/aes_mono_dup_pkg.sv
package aes_mono_dup_pkg;

   // Which kind of word cycle the scheduler starts in the current clock.
   typedef enum logic [1:0] {
      SLOT_IDLE  = 2'd0,   // no word this cycle
      SLOT_PAIR  = 2'd1,   // stereo: A left, B right
      SLOT_DUP_A = 2'd2,   // mono: A in both slots
      SLOT_DUP_B = 2'd3    // mono: held B in both slots
   } slot_e;

   localparam int unsigned MIN_DATA_W = 8;
   localparam int unsigned MIN_CNT_W  = 4;

endpackage

// File: rtl/aes_mono_dup_rate.sv
// Measures the spacing of frame strobes and derives the half-frame delay
// used to place the second mono word cycle.
module aes_mono_dup_rate #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned FIXED_HALF = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frm_stb,
   output logic [CNT_W-1:0] since_q,
   output logic [CNT_W-1:0] half_cyc
);
   import aes_mono_dup_pkg::*;

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

   if (CNT_W < MIN_CNT_W) begin : g_bad_cnt
      $error("aes_mono_dup_rate: CNT_W below minimum");
   end
   if (FIXED_HALF >= (1 << (CNT_W - 1))) begin : g_bad_fixed
      $error("aes_mono_dup_rate: FIXED_HALF does not fit CNT_W");
   end

   // Cycles elapsed since the last frame strobe (1 right after one), saturating.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_q <= '0;
      end else if (frm_stb) begin
         since_q <= CNT_ONE;
      end else if (since_q != CNT_MAX) begin
         since_q <= since_q + CNT_ONE;
      end
   end

   if (FIXED_HALF > 0) begin : g_fixed
      // Library variant: the half-frame delay is a build-time constant.
      assign half_cyc = CNT_W'(FIXED_HALF);
   end else begin : g_meas
      logic [CNT_W-1:0] period_q;
      logic             seen_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            period_q <= CNT_TWO;
            seen_q   <= 1'b0;
         end else if (frm_stb) begin
            seen_q <= 1'b1;
            if (seen_q) begin
               period_q <= since_q;
            end
         end
      end

      always_comb begin
         if (period_q < CNT_TWO) begin
            half_cyc = CNT_ONE;
         end else begin
            half_cyc = period_q >> 1;
         end
      end
   end

endmodule

// File: rtl/aes_mono_dup_sched.sv
// Frame-boundary mode latch, B-sample hold register, pending/overrun logic,
// and selection of the word cycle to start each clock.
module aes_mono_dup_sched #(
   parameter int unsigned DATA_W = 24,
   parameter int unsigned CNT_W  = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        frm_stb,
   input  logic                        mono_sel,
   input  logic [DATA_W-1:0]           sub_b,
   input  logic [CNT_W-1:0]            since_q,
   input  logic [CNT_W-1:0]            half_cyc,
   output aes_mono_dup_pkg::slot_e     slot,
   output logic [DATA_W-1:0]           b_held,
   output logic                        mode_q,
   output logic                        ovr_q
);
   import aes_mono_dup_pkg::*;

   logic pend_q;
   logic b_due;

   assign b_due = pend_q && (since_q == half_cyc);

   // A new frame always wins over a B word that falls due in the same cycle.
   always_comb begin
      if (frm_stb) begin
         slot = mono_sel ? SLOT_DUP_A : SLOT_PAIR;
      end else if (b_due) begin
         slot = SLOT_DUP_B;
      end else begin
         slot = SLOT_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         pend_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else if (frm_stb) begin
         mode_q <= mono_sel;
         pend_q <= mono_sel;
         ovr_q  <= pend_q;
      end else begin
         ovr_q <= 1'b0;
         if (b_due) begin
            pend_q <= 1'b0;
         end
      end
   end

   // Data-only register: no reset needed, loaded at each mono frame.
   always_ff @(posedge clk) begin
      if (frm_stb && mono_sel) begin
         b_held <= sub_b;
      end
   end

endmodule

// File: rtl/aes_mono_dup_outreg.sv
// Builds and registers the left/right word pair for the selected word cycle.
module aes_mono_dup_outreg #(
   parameter int unsigned DATA_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  aes_mono_dup_pkg::slot_e slot,
   input  logic [DATA_W-1:0]       sub_a,
   input  logic [DATA_W-1:0]       sub_b,
   input  logic [DATA_W-1:0]       b_held,
   output logic                    word_stb,
   output logic [DATA_W-1:0]       left_word,
   output logic [DATA_W-1:0]       right_word
);
   import aes_mono_dup_pkg::*;

   logic [DATA_W-1:0] left_d;
   logic [DATA_W-1:0] right_d;

   always_comb begin
      unique case (slot)
         SLOT_PAIR: begin
            left_d  = sub_a;
            right_d = sub_b;
         end
         SLOT_DUP_A: begin
            left_d  = sub_a;
            right_d = sub_a;
         end
         SLOT_DUP_B: begin
            left_d  = b_held;
            right_d = b_held;
         end
         default: begin
            left_d  = left_word;
            right_d = right_word;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_stb   <= 1'b0;
         left_word  <= '0;
         right_word <= '0;
      end else begin
         word_stb   <= (slot != SLOT_IDLE);
         left_word  <= left_d;
         right_word <= right_d;
      end
   end

endmodule

// File: rtl/aes_mono_dup.sv
module aes_mono_dup #(
   parameter int unsigned DATA_W     = 24,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned FIXED_HALF = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_stb,
   input  logic [DATA_W-1:0] sub_a,
   input  logic [DATA_W-1:0] sub_b,
   input  logic              mono_sel,
   output logic              word_stb,
   output logic [DATA_W-1:0] left_word,
   output logic [DATA_W-1:0] right_word,
   output logic              rate_x2,
   output logic              overrun
);
   import aes_mono_dup_pkg::*;

   if (DATA_W < MIN_DATA_W) begin : g_bad_data
      $error("aes_mono_dup: DATA_W below minimum");
   end

   logic [CNT_W-1:0]  since_q;
   logic [CNT_W-1:0]  half_cyc;
   logic [DATA_W-1:0] b_held;
   slot_e             slot;

   aes_mono_dup_rate #(
      .CNT_W      (CNT_W),
      .FIXED_HALF (FIXED_HALF)
   ) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .frm_stb  (frm_stb),
      .since_q  (since_q),
      .half_cyc (half_cyc)
   );

   aes_mono_dup_sched #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .frm_stb  (frm_stb),
      .mono_sel (mono_sel),
      .sub_b    (sub_b),
      .since_q  (since_q),
      .half_cyc (half_cyc),
      .slot     (slot),
      .b_held   (b_held),
      .mode_q   (rate_x2),
      .ovr_q    (overrun)
   );

   aes_mono_dup_outreg #(
      .DATA_W (DATA_W)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot       (slot),
      .sub_a      (sub_a),
      .sub_b      (sub_b),
      .b_held     (b_held),
      .word_stb   (word_stb),
      .left_word  (left_word),
      .right_word (right_word)
   );

endmodule

// File: rtl/aes_mono_dup_chk.sv
module aes_mono_dup_chk #(
   parameter int unsigned DATA_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_stb,
   input logic              mono_sel,
   input logic [DATA_W-1:0] sub_a,
   input logic [DATA_W-1:0] sub_b,
   input logic              word_stb,
   input logic [DATA_W-1:0] left_word,
   input logic [DATA_W-1:0] right_word,
   input logic              rate_x2,
   input logic              overrun
);

   // R2
   stereo_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_stb && !mono_sel |=> word_stb && left_word == $past(sub_a)
                               && right_word == $past(sub_b));

   // R3
   mono_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_stb && mono_sel |=> word_stb && left_word == $past(sub_a)
                              && right_word == $past(sub_a));

   // R6
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_stb |=> $stable(rate_x2));

   // R6
   mode_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_stb |=> rate_x2 == $past(mono_sel));

   // R7
   ovr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(frm_stb) && $past(rate_x2));

   // R4
   dup_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb && rate_x2 |-> left_word == right_word);

   // R8
   stereo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb && !rate_x2 |-> $past(frm_stb));

endmodule

bind aes_mono_dup aes_mono_dup_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frm_stb    (frm_stb),
   .mono_sel   (mono_sel),
   .sub_a      (sub_a),
   .sub_b      (sub_b),
   .word_stb   (word_stb),
   .left_word  (left_word),
   .right_word (right_word),
   .rate_x2    (rate_x2),
   .overrun    (overrun)
);

// File: tb/aes_mono_dup_tb.sv
`timescale 1ns/1ps
module aes_mono_dup_tb;
   localparam int DW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frm_stb = 1'b0;
   logic [DW-1:0] sub_a = '0;
   logic [DW-1:0] sub_b = '0;
   logic          mono_sel = 1'b0;
   logic          word_stb;
   logic [DW-1:0] left_word;
   logic [DW-1:0] right_word;
   logic          rate_x2;
   logic          overrun;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   aes_mono_dup #(.DATA_W(DW)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .frm_stb    (frm_stb),
      .sub_a      (sub_a),
      .sub_b      (sub_b),
      .mono_sel   (mono_sel),
      .word_stb   (word_stb),
      .left_word  (left_word),
      .right_word (right_word),
      .rate_x2    (rate_x2),
      .overrun    (overrun)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_word(input string tag, input logic [DW-1:0] l,
                           input logic [DW-1:0] r);
      chk(word_stb == 1'b1, {tag, " word_stb"}, 32'(word_stb), 32'd1);
      chk(left_word == l, {tag, " left"}, 32'(left_word), 32'(l));
      chk(right_word == r, {tag, " right"}, 32'(right_word), 32'(r));
   endtask

   // Drive a frame at the next edge; return just after that edge.
   task automatic strobe(input logic [DW-1:0] a, input logic [DW-1:0] b);
      frm_stb = 1'b1;
      sub_a   = a;
      sub_b   = b;
      @(negedge clk);
      frm_stb = 1'b0;
      sub_a   = 24'hDEAD01;
      sub_b   = 24'hBAD0B0;
   endtask

   // n idle cycles with no word pulse expected.
   task automatic idle_n(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(word_stb == 1'b0, tag, 32'(word_stb), 32'd0);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      frm_stb = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk(word_stb == 0, "R1 word_stb", 32'(word_stb), 0);
      chk(left_word == 0 && right_word == 0, "R1 words", 32'(left_word), 0);
      chk(rate_x2 == 0, "R1 rate_x2", 32'(rate_x2), 0);
      chk(overrun == 0, "R1 overrun", 32'(overrun), 0);
      idle_n(3, "R1 idle");
   endtask

   task automatic t_stereo();
      do_reset();
      mono_sel = 1'b0;
      strobe(24'h111111, 24'h222222);
      chk_word("R2 stereo f1", 24'h111111, 24'h222222);
      chk(rate_x2 == 0, "R6 rate stereo", 32'(rate_x2), 0);
      idle_n(15, "R8 stereo single");
      strobe(24'h333333, 24'h444444);
      chk_word("R2 stereo f2", 24'h333333, 24'h444444);
      idle_n(15, "R8 stereo single 2");
   endtask

   task automatic t_mono();
      do_reset();
      mono_sel = 1'b1;
      strobe(24'hA00001, 24'hB00001);
      chk_word("R3 mono A1", 24'hA00001, 24'hA00001);
      chk(rate_x2 == 1, "R6 rate mono", 32'(rate_x2), 1);
      @(negedge clk);
      chk_word("R4 first half=1 B1", 24'hB00001, 24'hB00001);
      idle_n(14, "R8 mono gap");
      strobe(24'hA00002, 24'hB00002);
      chk_word("R3 mono A2", 24'hA00002, 24'hA00002);
      chk(overrun == 0, "R7 no overrun", 32'(overrun), 0);
      idle_n(7, "R4 before half");
      @(negedge clk);
      chk_word("R4 R5 B2 at half=8", 24'hB00002, 24'hB00002);
      idle_n(7, "R8 mono tail");
   endtask

   // Continues from t_mono timing (one gap of 16 established).
   task automatic t_mode_switch();
      strobe(24'hA00003, 24'hB00003);
      mono_sel = 1'b0;
      chk_word("R3 mono A3", 24'hA00003, 24'hA00003);
      idle_n(7, "R6 B still pending");
      chk(rate_x2 == 1, "R6 rate held", 32'(rate_x2), 1);
      @(negedge clk);
      chk_word("R6 B3 kept mono", 24'hB00003, 24'hB00003);
      idle_n(7, "R6 gap");
      strobe(24'h555555, 24'h666666);
      chk_word("R6 stereo after switch", 24'h555555, 24'h666666);
      chk(rate_x2 == 0, "R6 rate switched", 32'(rate_x2), 0);
      idle_n(10, "R8 no B after switch");
   endtask

   task automatic t_overrun();
      do_reset();
      mono_sel = 1'b1;
      strobe(24'hC00001, 24'hD00001);
      @(negedge clk);
      chk_word("R4 B first", 24'hD00001, 24'hD00001);
      idle_n(14, "R8 gap");
      strobe(24'hC00002, 24'hD00002);
      chk_word("R3 A before ovr", 24'hC00002, 24'hC00002);
      chk(overrun == 0, "R7 no early ovr", 32'(overrun), 0);
      idle_n(2, "R7 pending");
      strobe(24'hC00003, 24'hD00003);
      chk(overrun == 1, "R7 overrun set", 32'(overrun), 1);
      chk_word("R7 new A kept", 24'hC00003, 24'hC00003);
      @(negedge clk);
      chk(overrun == 0, "R7 overrun one cycle", 32'(overrun), 0);
      chk_word("R7 R4 new B half=1", 24'hD00003, 24'hD00003);
      idle_n(10, "R7 old B dropped");
   endtask

   initial begin
      t_reset();
      t_stereo();
      t_mono();
      t_mode_switch();
      t_overrun();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(5ns * 100000);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule